// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front-End

This block is the control logic of a pipelined synchronous burst SRAM, together with a small internal word array. Every synchronous control input is sampled on the rising clock edge. A cycle may start a new access from either of two address strobes, a processor-side one and a controller-side one. It may continue the current burst through the advance input. It may also leave the device idle. The chip enables are checked only on cycles that start a new access. The low two address bits run in a linear burst that wraps inside a 4-word block. The upper bits stay fixed until the next start.

Writes are either global, which writes every byte lane, or per lane under a byte write enable and one select bit per lane. Reads take one register stage: data for the address that a rising edge takes in appears after that edge. The output enable gates the read data bus. It is held off for the first read after the device was deselected.

Top module: `sbsram_ctrl`

## Requirements
- R1: A start cycle selects the device only when ce_a_n=0, ce_b=1 and ce_c_n=0. A start with any other enable pattern deselects the device: nothing is written, and rdata_en stays 0 until a later start selects the device again.
- R2: A start cycle captures the full external address. It can be begun by proc_strb_n=0 with ce_a_n=0, or by ctrl_strb_n=0 with no honoured processor strobe.
- R3: When both strobes are low and ce_a_n=0, the processor strobe is honoured. A processor-begun start cycle is always a read, and the write controls have no effect on it.
- R4: proc_strb_n=0 is ignored while ce_a_n=1. With ctrl_strb_n=1 the cycle behaves as a burst continuation of the present state.
- R5: On cycles with no honoured strobe the chip enables are not sampled. A selected device stays selected and a deselected one stays deselected.
- R6: In a selected continuation cycle with adv_n=0, address bits 1:0 step by one, modulo 4. The upper bits stay unchanged. With adv_n=1 the address holds.
- R7: all_wr_n=0 in a write-capable selected cycle writes all four byte lanes of wdata, whatever byte_wr_n and lane_sel_n are.
- R8: With all_wr_n=1 and byte_wr_n=0, lane k (bits 8k+7:8k) is written only when lane_sel_n[k]=0, and the other lanes are kept. A selected cycle with both write controls high is a read.
- R9: After the rising edge that takes in a selected read cycle, rdata carries the word at that cycle's address. That word includes all writes done on earlier edges.
- R10: rdata_en=1 only when oe_n=0, the last edge took in a read, and that read was not the first one after a deselected state. When rdata_en=0, rdata is all zeros.
- R11: After reset the device is deselected, rdata_en=0 and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 6 | External word address |
| proc_strb_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low |
| ce_a_n | input | 1 | Chip enable A, active low |
| ce_b | input | 1 | Chip enable B, active high |
| ce_c_n | input | 1 | Chip enable C, active low |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write, active low |
| byte_wr_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | 4 | Per-lane byte selects, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, zero when not enabled |
| rdata_en | output | 1 | Read data is being driven |

## Verification
Most internal faults show up on the read bus within a few cycles. A wrong burst counter or upper address moves the following reads to another word, and that word's contents appear on rdata one edge after the read cycle. A wrong lane mask or a write let through on a processor start corrupts stored data. That damage shows only when the word is read back, so the directed sequences read each written word again soon after writing it. A stuck select or mask flag shows at once on rdata_en in the cycle after a start or a deselect.

// File: rtl/sbs_pkg.sv
// Shared types for the burst SRAM control front-end.
package sbs_pkg;
    // Kind of access start decoded for one clock cycle.
    typedef enum logic [1:0] {
        ST_NONE = 2'd0,   // no honoured strobe: burst continuation or idle
        ST_PROC = 2'd1,   // processor-side strobe, read-only start
        ST_CTRL = 2'd2    // controller-side strobe, write-capable start
    } start_e;
endpackage

// File: rtl/sbs_strobe_dec.sv
// Strobe and chip-enable decoder.
// Decides, from the sampled strobes and enables, whether this cycle starts
// a new access and whether the enable pattern selects the device.
// Assumes all inputs are stable around the rising edge (synchronous inputs).
module sbs_strobe_dec
    import sbs_pkg::*;
(
    input  logic   proc_strb_n,
    input  logic   ctrl_strb_n,
    input  logic   ce_a_n,
    input  logic   ce_b,
    input  logic   ce_c_n,
    output start_e start,
    output logic   en_ok
);
    logic proc_hit;
    logic ctrl_hit;

    // Processor strobe is only seen while enable A is active; it outranks the controller strobe.
    always_comb begin
        proc_hit = !proc_strb_n && !ce_a_n;
        ctrl_hit = !ctrl_strb_n && !proc_hit;
        if (proc_hit)
            start = ST_PROC;
        else if (ctrl_hit)
            start = ST_CTRL;
        else
            start = ST_NONE;
    end

    // Full enable qualification, used only by start cycles.
    always_comb begin
        en_ok = !ce_a_n && ce_b && !ce_c_n;
    end
endmodule

// File: rtl/sbs_addr_ctr.sv
// Burst address register.
// Holds the current word address; the low BW bits form a linear burst counter
// that wraps modulo 2**BW while the upper bits stay fixed.
// Assumes 'step' is only raised on selected continuation cycles.
module sbs_addr_ctr #(
    parameter int AW = 6,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] eff_addr
);
    logic [BW-1:0] cnt_inc;

    // Address in effect for this cycle: a new load, a stepped burst, or a hold.
    always_comb begin
        cnt_inc = cur_addr[BW-1:0] + 1'b1;
        if (load)
            eff_addr = ld_addr;
        else if (step)
            eff_addr = {cur_addr[AW-1:BW], cnt_inc};
        else
            eff_addr = cur_addr;
    end

    // Register the effective address for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else
            cur_addr <= eff_addr;
    end

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_addr == $past(ld_addr)); // R2
    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step) |=> cur_addr[BW-1:0] == BW'($past(cur_addr[BW-1:0]) + 1'b1)); // R6
    AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cur_addr[AW-1:BW] == $past(cur_addr[AW-1:BW])); // R6
endmodule

// File: rtl/sbs_wr_dec.sv
// Write-control decoder.
// Turns the global write, byte write enable and lane selects into per-lane
// write strobes. Assumes 'wr_allow' already folds in selection and the
// read-only rule for processor starts.
module sbs_wr_dec #(
    parameter int NB = 4
) (
    input  logic          wr_allow,
    input  logic          all_wr_n,
    input  logic          byte_wr_n,
    input  logic [NB-1:0] lane_sel_n,
    output logic          wr_cyc,
    output logic [NB-1:0] be
);
    // Global write wins over byte writes; byte writes follow the lane selects.
    always_comb begin
        wr_cyc = wr_allow && (!all_wr_n || !byte_wr_n);
        if (!wr_cyc)
            be = '0;
        else if (!all_wr_n)
            be = '1;
        else
            be = ~lane_sel_n;
    end
endmodule

// File: rtl/sbs_array.sv
// Word array with per-lane write strobes and a registered read port.
// Each byte lane is a separate storage array so that lanes are written
// independently. Read data is captured on the edge that takes the read in.
// Assumes 'rd_en' and 'be' are never both active.
module sbs_array #(
    parameter int DEPTH = 64,
    parameter int NB    = 4,
    parameter int LW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = NB * LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [NB-1:0] be,
    input  logic [DW-1:0] wdata,
    input  logic          rd_en,
    output logic [DW-1:0] rdata_q
);
    for (genvar k = 0; k < NB; k++) begin : g_lane
        logic [LW-1:0] lane_mem [DEPTH];
        logic [LW-1:0] lane_rd;

        // Clear on reset, else write this lane when its strobe is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++)
                    lane_mem[i] <= '0;
            end else if (be[k]) begin
                lane_mem[addr] <= wdata[k*LW +: LW];
            end
        end

        // Capture this lane's read data on a read cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_rd <= '0;
            else if (rd_en)
                lane_rd <= lane_mem[addr];
        end

        assign rdata_q[k*LW +: LW] = lane_rd;
    end

    AST_RD_NOT_WR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> be == '0); // R8
endmodule

// File: rtl/sbsram_ctrl.sv
// Synchronous burst SRAM control front-end (top).
// Combines strobe decode, burst addressing, write decode and the array, and
// tracks selection and the read pipeline to gate the read data bus.
// Assumes oe_n is the only input that is not sampled on the clock.
module sbsram_ctrl
    import sbs_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NB    = 4,
    parameter int LW    = 8,
    parameter int BW    = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = NB * LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          proc_strb_n,
    input  logic          ctrl_strb_n,
    input  logic          ce_a_n,
    input  logic          ce_b,
    input  logic          ce_c_n,
    input  logic          adv_n,
    input  logic          all_wr_n,
    input  logic          byte_wr_n,
    input  logic [NB-1:0] lane_sel_n,
    input  logic          oe_n,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_en
);
    start_e        start;
    logic          en_ok;
    logic          load;
    logic          sel_q;
    logic          sel_nxt;
    logic          step;
    logic          wr_allow;
    logic          wr_cyc;
    logic          rd_cyc;
    logic [NB-1:0] be;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] eff_addr;
    logic [DW-1:0] rdata_q;
    logic          rd_v_q;
    logic          first_q;

    sbs_strobe_dec u_dec (
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .ce_a_n      (ce_a_n),
        .ce_b        (ce_b),
        .ce_c_n      (ce_c_n),
        .start       (start),
        .en_ok       (en_ok)
    );

    // Cycle qualification: selection, burst step and write permission.
    always_comb begin
        load     = (start != ST_NONE);
        sel_nxt  = load ? en_ok : sel_q;
        step     = !load && sel_q && !adv_n;
        wr_allow = sel_nxt && (start != ST_PROC);
        rd_cyc   = sel_nxt && !wr_cyc;
    end

    sbs_addr_ctr #(.AW(AW), .BW(BW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ld_addr  (addr),
        .step     (step),
        .cur_addr (cur_addr),
        .eff_addr (eff_addr)
    );

    sbs_wr_dec #(.NB(NB)) u_wr (
        .wr_allow   (wr_allow),
        .all_wr_n   (all_wr_n),
        .byte_wr_n  (byte_wr_n),
        .lane_sel_n (lane_sel_n),
        .wr_cyc     (wr_cyc),
        .be         (be)
    );

    sbs_array #(.DEPTH(DEPTH), .NB(NB), .LW(LW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (eff_addr),
        .be      (be),
        .wdata   (wdata),
        .rd_en   (rd_cyc),
        .rdata_q (rdata_q)
    );

    // Selection state and read pipeline flags, including the first-read mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            rd_v_q  <= 1'b0;
            first_q <= 1'b0;
        end else begin
            sel_q   <= sel_nxt;
            rd_v_q  <= rd_cyc;
            first_q <= rd_cyc && !sel_q;
        end
    end

    // Output gating by output enable, read validity and the first-read mask.
    always_comb begin
        rdata_en = !oe_n && rd_v_q && !first_q;
        rdata    = rdata_en ? rdata_q : '0;
    end

    AST_PROC_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (start == ST_PROC) |-> be == '0); // R3
    AST_OE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> !rdata_en); // R10
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !en_ok) |=> !rdata_en); // R1
    AST_HOLD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (start == ST_NONE) |=> sel_q == $past(sel_q)); // R5
    AST_NO_WR_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_nxt |-> be == '0); // R1
endmodule

// File: tb/tb_sbsram_ctrl.sv
module tb_sbsram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int NB = 4;
    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          proc_strb_n, ctrl_strb_n, ce_a_n, ce_b, ce_c_n, adv_n;
    logic          all_wr_n, byte_wr_n, oe_n;
    logic [NB-1:0] lane_sel_n;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rdata_en;

    int n_checks = 0;
    int n_errors = 0;

    // reference state
    logic [DW-1:0] m_mem [DEPTH];
    logic          m_sel, m_rdv, m_first;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_rdq;

    sbsram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .adv_n(adv_n),
        .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .lane_sel_n(lane_sel_n),
        .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old,
                                                 input logic [DW-1:0] nw,
                                                 input logic [NB-1:0] en);
        logic [DW-1:0] r = old;
        for (int k = 0; k < NB; k++)
            if (en[k]) r[k*8 +: 8] = nw[k*8 +: 8];
        return r;
    endfunction

    function automatic logic exp_en();
        return !oe_n && m_rdv && !m_first;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference update for the inputs currently driven
    task automatic model_step();
        logic p, c, ld, ok, nsel, wr;
        logic [AW-1:0] eff;
        logic [NB-1:0] lanes;
        p  = !proc_strb_n && !ce_a_n;
        c  = !p && !ctrl_strb_n;
        ld = p || c;
        ok = !ce_a_n && ce_b && !ce_c_n;
        nsel = ld ? ok : m_sel;
        if (ld) eff = addr;
        else if (m_sel && !adv_n) eff = {m_addr[AW-1:2], 2'(m_addr[1:0] + 2'd1)};
        else eff = m_addr;
        wr = nsel && !p && (!all_wr_n || !byte_wr_n);
        lanes = !all_wr_n ? '1 : ~lane_sel_n;
        if (wr) m_mem[eff] = lane_merge(m_mem[eff], wdata, lanes);
        if (nsel && !wr) m_rdq = m_mem[eff];
        m_first = nsel && !wr && !m_sel;
        m_rdv = nsel && !wr;
        m_sel = nsel;
        m_addr = eff;
    endtask

    // one clock: inputs already driven at a negedge; check after the next posedge
    task automatic step(input string tag);
        logic e;
        model_step();
        @(posedge clk);
        @(negedge clk);
        e = exp_en();
        check(tag, {31'd0, rdata_en}, {31'd0, e});
        check(tag, rdata, e ? m_rdq : '0);
    endtask

    task automatic idle();
        proc_strb_n = 1; ctrl_strb_n = 1; adv_n = 1;
        all_wr_n = 1; byte_wr_n = 1; lane_sel_n = '1;
        ce_a_n = 0; ce_b = 1; ce_c_n = 0; oe_n = 0;
    endtask

    task automatic start_ctrl(input logic [AW-1:0] a);
        idle(); ctrl_strb_n = 0; addr = a;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(1234);
        idle(); addr = '0; wdata = '0; rst_n = 0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_sel = 0; m_rdv = 0; m_first = 0; m_addr = '0; m_rdq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R11 reset en", {31'd0, rdata_en}, 32'd0);
        check("R11 reset data", rdata, '0);

        // first read after deselect is masked, then burst read of cleared array
        start_ctrl(6'd5); step("R10 first read masked");
        idle(); adv_n = 0; step("R11 cleared word");
        step("R9 burst read");

        // controller start with global write, burst of byte writes
        start_ctrl(6'd8); all_wr_n = 0; byte_wr_n = 0; lane_sel_n = 4'b1111;
        wdata = 32'hA1B2C3D4; step("R7 global write");
        idle(); adv_n = 0; byte_wr_n = 0; lane_sel_n = 4'b1010;
        wdata = 32'h11223344; step("R8 lane write");
        idle(); adv_n = 0; byte_wr_n = 0; lane_sel_n = 4'b0101;
        wdata = 32'h55667788; step("R8 lane write");
        idle(); adv_n = 0; all_wr_n = 0; wdata = 32'hCAFEF00D; step("R7 global write");

        // read burst from 10 wraps 10,11,8,9
        start_ctrl(6'd10); step("R2 load read");
        idle(); adv_n = 0; step("R6 wrap 11");
        step("R6 wrap 8");
        step("R6 wrap 9");
        idle(); step("R6 hold");

        // both strobes with write controls low: processor wins, no write
        idle(); proc_strb_n = 0; ctrl_strb_n = 0; addr = 6'd8; all_wr_n = 0;
        wdata = 32'hDEADBEEF; step("R3 priority no write");
        idle(); step("R3 read back");

        // processor strobe ignored with ce_a_n high: continuation of burst
        idle(); adv_n = 0; proc_strb_n = 0; ce_a_n = 1; addr = 6'd40;
        step("R4 proc ignored");
        idle(); step("R4 hold after ignore");

        // continuation with enables invalid: still selected
        idle(); adv_n = 0; ce_b = 0; ce_c_n = 1; step("R5 no resample");

        // start with an invalid enable pattern deselects; writes ignored
        start_ctrl(6'd3); ce_c_n = 1; all_wr_n = 0; wdata = 32'h0BAD0BAD;
        step("R1 deselect");
        idle(); adv_n = 0; all_wr_n = 0; step("R1 stays deselected");
        start_ctrl(6'd3); step("R10 masked after deselect");
        idle(); oe_n = 1; step("R10 oe high");
        idle(); adv_n = 0; step("R1 no write while deselected");

        // constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            idle();
            addr        = AW'($urandom);
            wdata       = $urandom;
            proc_strb_n = ($urandom % 8) != 0;
            ctrl_strb_n = ($urandom % 6) != 0;
            ce_a_n      = ($urandom % 10) == 0;
            ce_b        = ($urandom % 10) != 0;
            ce_c_n      = ($urandom % 10) == 0;
            adv_n       = ($urandom % 2) == 0;
            all_wr_n    = ($urandom % 8) != 0;
            byte_wr_n   = ($urandom % 4) != 0;
            lane_sel_n  = NB'($urandom);
            oe_n        = ($urandom % 6) == 0;
            step("R9 random");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule